// File: doc/BRIEF.md
# Interrupt Source Coalescing State Controller

This block keeps a two-bit coalescing state for each of a set of interrupt sources and turns raw hardware trigger activity into at most one outstanding notification per source. Bit 1 of the state (P) means a notification has gone out and no end-of-interrupt has come back yet. Bit 0 (Q) means another trigger arrived while P was set. The state `01` (Q alone) masks the source. Notifications carrying the source number leave on a valid/ready port. When that port stalls, they wait in a small FIFO.

Software manages each source through a load/store request port. Each source owns a page of `2^PAGE_SHIFT` bytes starting at `source * 2^PAGE_SHIFT`. Loads at fixed offsets inside that page return the previous state and change it in the same cycle: end-of-interrupt, query, and force to any of the four states. In the split-page modes the lower half of the page is a trigger page and the upper half holds the management offsets. Sources marked level-sensitive track their input level, so a level still held at end-of-interrupt is not lost.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After reset every source state is `00`, `ntf_valid` is 0 and `rsp_valid` is 0.
- R2: A trigger moves state `00` to `10` and produces exactly one notification carrying the source number. It moves `10` to `11`, leaves `11` at `11` and leaves `01` at `01`, and none of those three produces a notification.
- R3: An end-of-interrupt moves `10` to `00`, and moves `11` to `10` with one new notification. It leaves `00` and `01` unchanged. A load end-of-interrupt returns 1 in data bit 0 if a new notification was produced and 0 otherwise, with all other bits zero.
- R4: Management loads decode address bits [11:8] of the management area as follows. 0x0–0x3 is end-of-interrupt and 0x8–0xB is query. 0xC, 0xD, 0xE and 0xF force the state to `00`, `01`, `10` and `11`. Query and force return the state held before the access in bits [1:0], with P in bit 1, Q in bit 0 and upper bits zero. Every load is answered with `rsp_valid` exactly one cycle after the request.
- R5: A store to management offsets 0x400–0x7FF performs end-of-interrupt only when `STORE_EOI_EN` is 1. Otherwise it leaves the state unchanged.
- R6: The source index is `req_addr >> PAGE_SHIFT`. With `PAGE_SHIFT` 13 or 17, a store anywhere in the lower half-page triggers that source, and management offsets sit in the upper half. With `PAGE_SHIFT` 12 or 16, a store to offsets 0x000–0x3FF triggers the source.
- R7: A load whose source index is `NUM_SRC` or greater, a load in the lower half-page of a split page, and a load at 0x400–0x7FF all return all ones and change no state. A store with an out-of-range index has no effect.
- R8: A level-sensitive source (its bit set in `LSI_MAP`) triggers on a rising input level. If its input is still high at end-of-interrupt, the trigger path runs again right after the end-of-interrupt transition.
- R9: While `ntf_ready` is low, notifications are held with `ntf_valid` high and `ntf_src` stable. None is lost, even beyond the FIFO depth. Sources that become due in the same cycle are delivered lowest index first.
- R10: When a management access and a hardware trigger hit the same source in one cycle, the management operation applies first and the trigger second. The load returns the state from before both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Hardware trigger pulses (edge sources) or levels (level sources) |
| req_valid | input | 1 | Access request strobe, one access per cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Load response valid, one cycle after the load |
| rsp_data | output | DATA_W | Load response data |
| ntf_valid | output | 1 | Notification available |
| ntf_ready | input | 1 | Notification consumer ready |
| ntf_src | output | SRC_W | Source number of the notification |

## Verification
The bench targets coalescing: repeated triggers on a pending source must not emit again. A design that failed this would deliver extra source numbers, and the scoreboard flags them as unexpected. It checks that re-firing on end-of-interrupt from `11` and held-level re-triggering each deliver exactly one new notification and report it through the load data. A broken version would return 0 or lose a notification. Out-of-range indices are chosen to alias an in-range source, so a decoder that drops high index bits would disturb that source or emit for it. A burst of five simultaneous triggers under stall exceeds the FIFO depth, which exposes lost or reordered notifications. A same-cycle force-and-trigger exposes a wrong ordering of management and hardware updates.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_TRIG,
      OP_EOI,
      OP_GET,
      OP_SET,
      OP_BAD
   } pq_op_e;

   typedef struct packed {
      logic [1:0] pq;
      logic       fire;
   } pq_step_t;

   localparam logic [1:0] PQ_IDLE = 2'b00;
   localparam logic [1:0] PQ_OFF  = 2'b01;
   localparam logic [1:0] PQ_PEND = 2'b10;
   localparam logic [1:0] PQ_QUED = 2'b11;

   // Trigger step: only idle sources notify; pending ones remember the hit.
   function automatic pq_step_t pq_on_trigger(input logic [1:0] cur);
      pq_step_t r;
      r.fire = 1'b0;
      case (cur)
         PQ_IDLE: begin
            r.pq   = PQ_PEND;
            r.fire = 1'b1;
         end
         PQ_PEND, PQ_QUED: r.pq = PQ_QUED;
         default:          r.pq = cur;
      endcase
      return r;
   endfunction

   // End-of-interrupt step: a remembered hit turns into a fresh notification.
   function automatic pq_step_t pq_on_eoi(input logic [1:0] cur);
      pq_step_t r;
      r.fire = 1'b0;
      case (cur)
         PQ_PEND: r.pq = PQ_IDLE;
         PQ_QUED: begin
            r.pq   = PQ_PEND;
            r.fire = 1'b1;
         end
         default: r.pq = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/irq_pq_dec.sv
module irq_pq_dec
   import irq_pq_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int PAGE_SHIFT   = 12,
   parameter int NUM_SRC      = 8,
   parameter int SRC_W        = 3,
   parameter bit STORE_EOI_EN = 1'b1
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output pq_op_e            dec_op,
   output logic [1:0]        dec_setv,
   output logic [SRC_W-1:0]  dec_src,
   output logic              dec_hit
);

   localparam int IDX_W    = ADDR_W - PAGE_SHIFT;
   localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

   logic [IDX_W-1:0] idx;
   logic [3:0]       sub;
   logic             st_trig;
   logic             in_mgmt;
   logic             addr_unused_fold;

   assign idx              = req_addr[ADDR_W-1:PAGE_SHIFT];
   assign sub              = req_addr[11:8];
   assign dec_hit          = req_valid && (idx < IDX_W'(NUM_SRC));
   assign dec_src          = idx[SRC_W-1:0];
   assign dec_setv         = sub[1:0];
   assign addr_unused_fold = ^req_addr;

   generate
      if (TWO_PAGE) begin : g_split
         assign st_trig = !req_addr[PAGE_SHIFT-1];
         assign in_mgmt = req_addr[PAGE_SHIFT-1];
      end else begin : g_shared
         assign st_trig = (sub[3:2] == 2'b00);
         assign in_mgmt = 1'b1;
      end
   endgenerate

   always_comb begin
      dec_op = OP_NONE;
      if (req_valid) begin
         if (!dec_hit) begin
            dec_op = req_write ? OP_NONE : OP_BAD;
         end else if (req_write) begin
            if (st_trig)
               dec_op = OP_TRIG;
            else if (in_mgmt && (sub[3:2] == 2'b01) && STORE_EOI_EN)
               dec_op = OP_EOI;
         end else if (!in_mgmt) begin
            dec_op = OP_BAD;
         end else begin
            case (sub[3:2])
               2'b00:   dec_op = OP_EOI;
               2'b01:   dec_op = OP_BAD;
               2'b10:   dec_op = OP_GET;
               default: dec_op = OP_SET;
            endcase
         end
      end
   end

endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
   import irq_pq_pkg::*;
#(
   parameter bit IS_LSI = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_in,
   input  logic       sel,
   input  pq_op_e     op,
   input  logic [1:0] setv,
   input  logic       take,
   output logic [1:0] pq,
   output logic       owed,
   output logic       refire
);

   logic [1:0] pq_q;
   logic       owed_q;
   logic       lvl_q;
   logic       hw_t;
   logic       mmio_t;
   logic       lvl_t;
   logic       eoi_hit;
   pq_step_t   s_mmio;
   pq_step_t   s_lvl;
   pq_step_t   s_hw;

   generate
      if (IS_LSI) begin : g_level
         assign hw_t = src_in && !lvl_q;
      end else begin : g_edge
         assign hw_t = src_in;
      end
   endgenerate

   // Management first, then the held-level replay, then the hardware trigger.
   always_comb begin
      s_mmio  = '{pq: pq_q, fire: 1'b0};
      mmio_t  = 1'b0;
      eoi_hit = 1'b0;
      if (sel) begin
         case (op)
            OP_EOI: begin
               s_mmio  = pq_on_eoi(pq_q);
               eoi_hit = 1'b1;
            end
            OP_SET:  s_mmio.pq = setv;
            OP_TRIG: mmio_t    = 1'b1;
            default: ;
         endcase
      end
      lvl_t = eoi_hit && IS_LSI && lvl_q;
      s_lvl = lvl_t ? pq_on_trigger(s_mmio.pq) : '{pq: s_mmio.pq, fire: 1'b0};
      s_hw  = (hw_t || mmio_t) ? pq_on_trigger(s_lvl.pq) : '{pq: s_lvl.pq, fire: 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pq_q   <= PQ_IDLE;
         owed_q <= 1'b0;
         lvl_q  <= 1'b0;
      end else begin
         pq_q   <= s_hw.pq;
         owed_q <= (owed_q && !take) || s_mmio.fire || s_lvl.fire || s_hw.fire;
         lvl_q  <= IS_LSI ? src_in : 1'b0;
      end
   end

   assign pq     = pq_q;
   assign owed   = owed_q;
   assign refire = s_mmio.fire || s_lvl.fire;

   AST_TRIG_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && hw_t && pq_q == PQ_IDLE) |=> (pq_q == PQ_PEND && owed_q)); // R2
   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && pq_q == PQ_OFF) |=> (pq_q == PQ_OFF)); // R2
   AST_QUEUED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && pq_q == PQ_QUED) |=> (pq_q == PQ_QUED)); // R2
   AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op == OP_EOI && pq_q == PQ_PEND && !lvl_q && !hw_t) |=> (pq_q == PQ_IDLE)); // R3

endmodule

// File: rtl/irq_pq_fifo.sv
module irq_pq_fifo #(
   parameter int WIDTH = 3,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             full,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);

   generate
      if (DEPTH == 1) begin : g_slot
         logic             held_q;
         logic [WIDTH-1:0] data_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               held_q <= 1'b0;
            else if (!held_q && in_valid)
               held_q <= 1'b1;
            else if (held_q && out_ready)
               held_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (!held_q && in_valid)
               data_q <= in_data;
         end

         assign full      = held_q;
         assign out_valid = held_q;
         assign out_data  = data_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);

         logic [WIDTH-1:0] mem [DEPTH];
         logic [PTR_W-1:0] wr_q;
         logic [PTR_W-1:0] rd_q;
         logic [CNT_W-1:0] cnt_q;
         logic             do_push;
         logic             do_pop;

         assign full      = (cnt_q == CNT_W'(DEPTH));
         assign out_valid = (cnt_q != '0);
         assign out_data  = mem[rd_q];
         assign do_push   = in_valid && !full;
         assign do_pop    = out_valid && out_ready;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push)
                  wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
               if (do_pop)
                  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
               if (do_push && !do_pop)
                  cnt_q <= cnt_q + 1'b1;
               else if (do_pop && !do_push)
                  cnt_q <= cnt_q - 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (do_push)
               mem[wr_q] <= in_data;
         end
      end
   endgenerate

   AST_NTF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

// File: rtl/irq_pq_ctrl.sv
module irq_pq_ctrl
   import irq_pq_pkg::*;
#(
   parameter int                 NUM_SRC      = 8,
   parameter int                 PAGE_SHIFT   = 12,
   parameter int                 ADDR_W       = 24,
   parameter int                 DATA_W       = 64,
   parameter int                 FIFO_DEPTH   = 4,
   parameter bit                 STORE_EOI_EN = 1'b1,
   parameter logic [NUM_SRC-1:0] LSI_MAP      = '0,
   localparam int                SRC_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               ntf_valid,
   input  logic               ntf_ready,
   output logic [SRC_W-1:0]   ntf_src
);

   generate
      if (!(PAGE_SHIFT == 12 || PAGE_SHIFT == 13 || PAGE_SHIFT == 16 || PAGE_SHIFT == 17)) begin : g_bad_shift
         $error("PAGE_SHIFT must be 12, 13, 16 or 17");
      end
      if (NUM_SRC < 2) begin : g_bad_nsrc
         $error("NUM_SRC must be at least 2");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < PAGE_SHIFT + SRC_W) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_SRC pages");
      end
   endgenerate

   pq_op_e                    dec_op;
   logic [1:0]                dec_setv;
   logic [SRC_W-1:0]          dec_src;
   logic                      dec_hit;
   logic [NUM_SRC-1:0][1:0]   pq_all;
   logic [NUM_SRC-1:0]        owed_all;
   logic [NUM_SRC-1:0]        refire_all;
   logic [NUM_SRC-1:0]        take;
   logic [SRC_W-1:0]          pick;
   logic                      pick_any;
   logic                      fifo_full;
   logic                      push;
   logic [DATA_W-1:0]         rd_word;

   irq_pq_dec #(
      .ADDR_W       (ADDR_W),
      .PAGE_SHIFT   (PAGE_SHIFT),
      .NUM_SRC      (NUM_SRC),
      .SRC_W        (SRC_W),
      .STORE_EOI_EN (STORE_EOI_EN)
   ) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .dec_op    (dec_op),
      .dec_setv  (dec_setv),
      .dec_src   (dec_src),
      .dec_hit   (dec_hit)
   );

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         logic hit_me;
         assign hit_me  = dec_hit && (dec_src == SRC_W'(g)) && (dec_op != OP_NONE);
         assign take[g] = push && (pick == SRC_W'(g));

         irq_pq_cell #(
            .IS_LSI (LSI_MAP[g])
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_in (src_in[g]),
            .sel    (hit_me),
            .op     (dec_op),
            .setv   (dec_setv),
            .take   (take[g]),
            .pq     (pq_all[g]),
            .owed   (owed_all[g]),
            .refire (refire_all[g])
         );
      end
   endgenerate

   // Lowest-numbered owed source enters the queue first.
   always_comb begin
      pick     = '0;
      pick_any = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (owed_all[i]) begin
            pick     = SRC_W'(i);
            pick_any = 1'b1;
         end
      end
   end

   assign push = pick_any && !fifo_full;

   irq_pq_fifo #(
      .WIDTH (SRC_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (push),
      .in_data   (pick),
      .full      (fifo_full),
      .out_valid (ntf_valid),
      .out_ready (ntf_ready),
      .out_data  (ntf_src)
   );

   always_comb begin
      if (!dec_hit || dec_op == OP_BAD)
         rd_word = '1;
      else if (dec_op == OP_EOI)
         rd_word = DATA_W'(refire_all[dec_src]);
      else
         rd_word = DATA_W'(pq_all[dec_src]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         if (req_valid && !req_write)
            rsp_data <= rd_word;
      end
   end

   AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid); // R4
   AST_OOR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !dec_hit) |=> (rsp_data == {DATA_W{1'b1}})); // R7
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid); // R4

endmodule

// File: tb/irq_pq_ctrl_test.sv
module irq_pq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_in = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        ntf_valid;
   logic        ntf_ready = 1'b1;
   logic [2:0]  ntf_src;

   logic [7:0]  b_src_in = '0;
   logic        b_req_valid = 1'b0;
   logic        b_req_write = 1'b0;
   logic [23:0] b_req_addr = '0;
   logic        b_rsp_valid;
   logic [63:0] b_rsp_data;
   logic        b_ntf_valid;
   logic [2:0]  b_ntf_src;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];

   always #10 clk = ~clk;

   irq_pq_ctrl #(
      .NUM_SRC (8), .PAGE_SHIFT (13), .ADDR_W (24), .DATA_W (64),
      .FIFO_DEPTH (4), .STORE_EOI_EN (1'b1), .LSI_MAP (8'hC0)
   ) uut (
      .clk (clk), .rst_n (rst_n), .src_in (src_in),
      .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_data (rsp_data),
      .ntf_valid (ntf_valid), .ntf_ready (ntf_ready), .ntf_src (ntf_src)
   );

   irq_pq_ctrl #(
      .NUM_SRC (8), .PAGE_SHIFT (12), .ADDR_W (24), .DATA_W (64),
      .FIFO_DEPTH (4), .STORE_EOI_EN (1'b0), .LSI_MAP (8'h00)
   ) uut_b (
      .clk (clk), .rst_n (rst_n), .src_in (b_src_in),
      .req_valid (b_req_valid), .req_write (b_req_write), .req_addr (b_req_addr),
      .rsp_valid (b_rsp_valid), .rsp_data (b_rsp_data),
      .ntf_valid (b_ntf_valid), .ntf_ready (1'b1), .ntf_src (b_ntf_src)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [23:0] mg(input int s, input logic [11:0] off);
      return (24'(s) << 13) | 24'h1000 | 24'(off);
   endfunction

   function automatic logic [23:0] tp(input int s);
      return 24'(s) << 13;
   endfunction

   task automatic ld(input logic [23:0] a, input logic [7:0] pulse, output logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; src_in = src_in | pulse;
      @(negedge clk);
      req_valid = 1'b0; src_in = src_in & ~pulse;
      check("R4 response strobe", 64'(rsp_valid), 64'd1);
      d = rsp_data;
   endtask

   task automatic st(input logic [23:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk); src_in = src_in | m;
      @(negedge clk); src_in = src_in & ~m;
   endtask

   task automatic get_chk(input int s, input logic [1:0] exp, input string req);
      logic [63:0] d;
      ld(mg(s, 12'h800), 8'h00, d);
      check(req, d, 64'(exp));
   endtask

   task automatic b_ld(input logic [23:0] a, output logic [63:0] d);
      @(negedge clk);
      b_req_valid = 1'b1; b_req_write = 1'b0; b_req_addr = a;
      @(negedge clk);
      b_req_valid = 1'b0;
      d = b_rsp_data;
   endtask

   task automatic b_st(input logic [23:0] a);
      @(negedge clk);
      b_req_valid = 1'b1; b_req_write = 1'b1; b_req_addr = a;
      @(negedge clk);
      b_req_valid = 1'b0; b_req_write = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 60 && exp_q.size() != 0; k++) @(negedge clk);
      repeat (6) @(negedge clk);
      check("R9 all expected notifications delivered", 64'(exp_q.size()), 64'd0);
   endtask

   // Scoreboard monitor, sampling mid-cycle.
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rst_n && ntf_valid && ntf_ready) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R2 R9 unexpected notification: actual %0d expected none", ntf_src);
            end else begin
               int e;
               e = exp_q.pop_front();
               check("R9 notification source", 64'(ntf_src), 64'(e));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ntf_valid after reset", 64'(ntf_valid), 64'd0);
      check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      get_chk(0, 2'b00, "R1 source 0 idle");
      get_chk(7, 2'b00, "R1 source 7 idle");

      // R2 trigger transitions and coalescing
      exp_q.push_back(2);
      pulse(8'h04);
      get_chk(2, 2'b10, "R2 idle to pending");
      pulse(8'h04);
      get_chk(2, 2'b11, "R2 pending to queued");
      pulse(8'h04);
      get_chk(2, 2'b11, "R2 queued stays queued");
      drain();

      // R3 end-of-interrupt transitions
      exp_q.push_back(2);
      ld(mg(2, 12'h000), 8'h00, d);
      check("R3 load EOI from queued reports refire", d, 64'd1);
      get_chk(2, 2'b10, "R3 queued to pending");
      ld(mg(2, 12'h000), 8'h00, d);
      check("R3 load EOI from pending reports none", d, 64'd0);
      get_chk(2, 2'b00, "R3 pending to idle");
      ld(mg(2, 12'h000), 8'h00, d);
      check("R3 load EOI on idle", d, 64'd0);
      get_chk(2, 2'b00, "R3 idle unchanged");
      drain();

      // R4 force offsets return old state
      ld(mg(1, 12'hD00), 8'h00, d);
      check("R4 force 01 returns old", d, 64'd0);
      get_chk(1, 2'b01, "R4 state is off");
      pulse(8'h02);
      get_chk(1, 2'b01, "R2 off ignores trigger");
      ld(mg(1, 12'hF00), 8'h00, d);
      check("R4 force 11 returns old", d, 64'd1);
      ld(mg(1, 12'hE00), 8'h00, d);
      check("R4 force 10 returns old", d, 64'd3);
      ld(mg(1, 12'hC00), 8'h00, d);
      check("R4 force 00 returns old", d, 64'd2);
      get_chk(1, 2'b00, "R4 state is idle");
      drain();

      // R5 store EOI enabled on uut, disabled on uut_b
      exp_q.push_back(4);
      pulse(8'h10);
      st(mg(4, 12'h400));
      get_chk(4, 2'b00, "R5 store EOI honoured");
      b_ld(24'h004E00, d);
      check("R5 b force 10 returns old", d, 64'd0);
      b_st(24'h004400);
      b_ld(24'h004800, d);
      check("R5 store EOI ignored when disabled", d, 64'd2);

      // R6 page layout
      b_st(24'h005000);
      b_ld(24'h005800, d);
      check("R6 single-page store at 0x000 triggers", d, 64'd2);
      b_st(24'h006C00);
      b_ld(24'h006800, d);
      check("R6 single-page store at 0xC00 does not trigger", d, 64'd0);
      exp_q.push_back(5);
      st(tp(5));
      get_chk(5, 2'b10, "R6 split-page trigger page store triggers");
      drain();

      // R7 out-of-range and invalid loads
      ld(mg(9, 12'h800), 8'h00, d);
      check("R7 out-of-range load all ones", d, '1);
      ld(tp(2), 8'h00, d);
      check("R7 trigger-half load all ones", d, '1);
      ld(mg(2, 12'h400), 8'h00, d);
      check("R7 load at store-EOI window all ones", d, '1);
      st(tp(9));
      ld(mg(9, 12'hE00), 8'h00, d);
      check("R7 out-of-range force returns ones", d, '1);
      get_chk(1, 2'b00, "R7 aliased source untouched");
      get_chk(2, 2'b00, "R7 trigger-half load left state");
      drain();

      // R8 level-sensitive source 6
      exp_q.push_back(6);
      @(negedge clk); src_in[6] = 1'b1;
      repeat (3) @(negedge clk);
      get_chk(6, 2'b10, "R8 rising level triggers");
      exp_q.push_back(6);
      ld(mg(6, 12'h000), 8'h00, d);
      check("R8 EOI with level held reports refire", d, 64'd1);
      get_chk(6, 2'b10, "R8 held level re-triggers");
      @(negedge clk); src_in[6] = 1'b0;
      @(negedge clk);
      ld(mg(6, 12'h000), 8'h00, d);
      check("R8 EOI after level drop reports none", d, 64'd0);
      get_chk(6, 2'b00, "R8 idle after level drop");
      drain();

      // R9 stall with more due sources than FIFO entries
      @(negedge clk); ntf_ready = 1'b0;
      for (int s = 0; s < 5; s++) exp_q.push_back(s);
      pulse(8'h1F);
      repeat (8) @(negedge clk);
      check("R9 valid held under stall", 64'(ntf_valid), 64'd1);
      check("R9 lowest index at head", 64'(ntf_src), 64'd0);
      @(negedge clk);
      check("R9 head stable under stall", 64'(ntf_src), 64'd0);
      ntf_ready = 1'b1;
      drain();

      // R10 same-cycle force 00 plus hardware trigger on source 3
      exp_q.push_back(3);
      ld(mg(3, 12'hC00), 8'h08, d);
      check("R10 load returns state before both", d, 64'd2);
      get_chk(3, 2'b10, "R10 trigger applied after force");
      drain();

      summary();
      $finish;
   end

endmodule